// File: doc/BRIEF.md
# Receive Frame Queue with Sticky Status

This block parks complete received frames until software collects them. The receive path delivers each frame as a single strobe carrying one payload word. The block keeps up to three frames in arrival order. Software reads the oldest frame through a word-wide register port. It then frees that slot by setting a self-clearing release bit in the status word.

The status word holds the number of frames held, plus two sticky flags: one marks that the queue filled up, and one marks that a frame was dropped. Software clears either flag by writing 1 to it. Three interrupt lines report queue-not-empty, queue-full and dropped-frame. Each line is masked by its own enable bit in a separate enable word. Register accesses are full 32-bit words selected by a 2-bit word index: 0 is status, 1 is interrupt enable, and 2 is the oldest frame, which is read-only. Index 3 reads as zero.

Top module: `rx_frame_queue`

## Requirements
- R1: The status word (index 0) carries the frame count in bits 1:0, the full flag in bit 3, the overflow flag in bit 4 and the release-pending bit in bit 5. Bits 31:6 and bit 2 read as zero.
- R2: Frames leave in arrival order. Index 2 reads the payload of the oldest held frame, or zero when the queue is empty. Writes to index 2 have no effect.
- R3: Each accepted frame raises the count by one, up to a capacity of 3 frames.
- R4: The full flag sets on the edge where an accepted frame leaves the queue holding 3 frames. It stays set until software writes 1 to status bit 3. Writing 0 to that bit leaves it unchanged.
- R5: A frame that arrives while the queue holds 3 frames, with no release completing in that cycle, is dropped. The held frames and the count stay unchanged, and the overflow flag sets. The overflow flag stays set until software writes 1 to status bit 4. Writing 0 to that bit leaves it unchanged.
- R6: Writing 1 to status bit 5 while the count is nonzero makes bit 5 read 1 for one cycle. On the following edge the oldest frame is removed, the count drops by one, and bit 5 reads 0. A write of bit 5 while a release is already pending is ignored.
- R7: Writing 1 to status bit 5 while the queue is empty leaves the count, the contents and bit 5 unchanged.
- R8: When a set event for the full or overflow flag coincides with a write-1 clear of the same flag, the flag ends up set.
- R9: The enable word (index 1) holds bit 0 for not-empty, bit 1 for full and bit 2 for overflow; its other bits read as zero. The output irq_nempty_o equals (count != 0) AND bit 0. The output irq_full_o equals the full flag AND bit 1. The output irq_ovf_o equals the overflow flag AND bit 2.
- R10: After reset, the count, all flags, the release-pending bit and all enable bits are zero.
- R11: A frame that arrives in the cycle a release completes is accepted even when the queue held 3 frames. The count stays the same, and the full flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_valid_i | input | 1 | Frame arrival strobe, one cycle per frame |
| frm_data_i | input | DATA_W | Payload word of the arriving frame |
| reg_addr_i | input | 2 | Register word index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_nempty_o | output | 1 | Queue-not-empty interrupt |
| irq_full_o | output | 1 | Queue-full interrupt |
| irq_ovf_o | output | 1 | Dropped-frame interrupt |

## Verification
A wrong pointer or count appears within one cycle in the status count or in the oldest-frame word. A wrong pointer also stays visible on later reads, because every following release exposes a payload out of order. A flag that sets or clears on the wrong event shows up at the next read of status bits 3 and 4. The same fault appears on the matching interrupt line when that line is enabled. A release that completes too early or too late is caught by reading the pending bit and the count in the single cycle between the write and the removal.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] IDX_STAT = 2'd0;
  localparam logic [REG_AW-1:0] IDX_IEN  = 2'd1;
  localparam logic [REG_AW-1:0] IDX_HEAD = 2'd2;

  // status word layout
  localparam int CNT_LSB  = 0;
  localparam int CNT_FW   = 2;
  localparam int BIT_FULL = 3;
  localparam int BIT_OVF  = 4;
  localparam int BIT_DEQ  = 5;

  // interrupt lines, also enable bit positions
  localparam int IRQ_NE  = 0;
  localparam int IRQ_FU  = 1;
  localparam int IRQ_OV  = 2;
  localparam int NUM_IRQ = 3;

  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] head_o,
  output logic              full_set_o,
  output logic              ovf_set_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0]    LAST_P = PW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP    = CNT_W'(DEPTH);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_eff, accept;

  assign pop_eff = pop_i && (cnt_q != '0);
  // a completing release frees a slot for a same-cycle arrival
  assign accept  = push_i && ((cnt_q != CAP) || pop_eff);
  assign cnt_d   = cnt_q + CNT_W'(accept) - CNT_W'(pop_eff);

  assign full_set_o = accept && (cnt_d == CAP);
  assign ovf_set_o  = push_i && !accept;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 slot_q[g] <= '0;
      else if (accept && (wr_ptr_q == PW'(g)))     slot_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (accept)  wr_ptr_q <= (wr_ptr_q == LAST_P) ? '0 : wr_ptr_q + 1'b1;
      if (pop_eff) rd_ptr_q <= (rd_ptr_q == LAST_P) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign head_o = (cnt_q != '0) ? slot_q[rd_ptr_q] : '0;

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP);

  assert_drop_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && (cnt_q == CAP) && !pop_i) |=> ($stable(cnt_q) && $stable(wr_ptr_q)));

  assert_pop_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_we_i,
  input  logic clr_full_i,
  input  logic clr_ovf_i,
  input  logic deq_req_i,
  input  logic cnt_nz_i,
  input  logic full_set_i,
  input  logic ovf_set_i,
  output logic full_o,
  output logic ovf_o,
  output logic pend_o
);
  logic full_q, ovf_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // set beats a same-cycle write-1 clear
      full_q <= full_set_i || (full_q && !(stat_we_i && clr_full_i));
      ovf_q  <= ovf_set_i  || (ovf_q  && !(stat_we_i && clr_ovf_i));
      pend_q <= pend_q ? 1'b0 : (stat_we_i && deq_req_i && cnt_nz_i);
    end
  end

  assign full_o = full_q;
  assign ovf_o  = ovf_q;
  assign pend_o = pend_q;

  assert_deq_selfclr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> !pend_q);

  assert_full_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_set_i |=> full_q);

  assert_ovf_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_q);

  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(stat_we_i && clr_ovf_i)) |=> ovf_q);

  assert_full_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !(stat_we_i && clr_full_i)) |=> full_q);

  assert_deq_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_nz_i && !pend_q) |=> !pend_q);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ien_we_i,
  input  irq_vec_t ien_wdata_i,
  input  irq_vec_t cond_i,
  output irq_vec_t ien_o,
  output irq_vec_t irq_o
);
  irq_vec_t ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_q <= '0;
    else if (ien_we_i) ien_q <= ien_wdata_i;
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    assign irq_o[k] = cond_i[k] & ien_q[k];
  end

  assign ien_o = ien_q;

  assert_ien_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_we_i |=> $stable(ien_q));
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_nempty_o,
  output logic              irq_full_o,
  output logic              irq_ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] head;
  logic              full_set, ovf_set, pop;
  logic              full_flag, ovf_flag;
  logic              stat_we, ien_we;
  irq_vec_t          cond, ien, irq;
  logic [31:0]       stat_word, ien_word;
  logic              unused_wdata;

  assign stat_we = reg_we_i && (reg_addr_i == IDX_STAT);
  assign ien_we  = reg_we_i && (reg_addr_i == IDX_IEN);
  assign unused_wdata = ^{reg_wdata_i[31:BIT_DEQ+1], reg_wdata_i[2]};

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (frm_valid_i),
    .data_i     (frm_data_i),
    .pop_i      (pop),
    .cnt_o      (cnt),
    .head_o     (head),
    .full_set_o (full_set),
    .ovf_set_o  (ovf_set)
  );

  rxq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_we_i  (stat_we),
    .clr_full_i (reg_wdata_i[BIT_FULL]),
    .clr_ovf_i  (reg_wdata_i[BIT_OVF]),
    .deq_req_i  (reg_wdata_i[BIT_DEQ]),
    .cnt_nz_i   (cnt != '0),
    .full_set_i (full_set),
    .ovf_set_i  (ovf_set),
    .full_o     (full_flag),
    .ovf_o      (ovf_flag),
    .pend_o     (pop)
  );

  always_comb begin
    cond         = '0;
    cond[IRQ_NE] = (cnt != '0);
    cond[IRQ_FU] = full_flag;
    cond[IRQ_OV] = ovf_flag;
  end

  rxq_irq u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ien_we_i    (ien_we),
    .ien_wdata_i (reg_wdata_i[NUM_IRQ-1:0]),
    .cond_i      (cond),
    .ien_o       (ien),
    .irq_o       (irq)
  );

  assign irq_nempty_o = irq[IRQ_NE];
  assign irq_full_o   = irq[IRQ_FU];
  assign irq_ovf_o    = irq[IRQ_OV];

  always_comb begin
    stat_word                     = '0;
    stat_word[CNT_LSB +: CNT_FW]  = CNT_FW'(cnt);
    stat_word[BIT_FULL]           = full_flag;
    stat_word[BIT_OVF]            = ovf_flag;
    stat_word[BIT_DEQ]            = pop;
    ien_word                      = '0;
    ien_word[NUM_IRQ-1:0]         = ien;
  end

  always_comb begin
    case (reg_addr_i)
      IDX_STAT: reg_rdata_o = stat_word;
      IDX_IEN:  reg_rdata_o = ien_word;
      IDX_HEAD: reg_rdata_o = 32'(head);
      default:  reg_rdata_o = '0;
    endcase
  end

  assert_stat_rsvd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_word[31:BIT_DEQ+1] == '0) && !stat_word[2]);

  assert_nempty_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_nempty_o |-> (head == head) && (cnt != '0));
endmodule

// File: tb/rx_frame_queue_bench.sv
module rx_frame_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_valid = 1'b0;
  logic [DATA_W-1:0] frm_data = '0;
  logic [1:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq_ne, irq_fu, irq_ov;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_q [DEPTH];
  int m_cnt;
  bit m_full, m_ovf, m_pend;
  logic [2:0] m_en;

  rx_frame_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_frame_queue (
    .clk_i(clk), .rst_ni(rst_n), .frm_valid_i(frm_valid), .frm_data_i(frm_data),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_nempty_o(irq_ne), .irq_full_o(irq_fu), .irq_ovf_o(irq_ov)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = '0;
    s[1:0] = 2'(m_cnt);
    s[3] = m_full;
    s[4] = m_ovf;
    s[5] = m_pend;
    return s;
  endfunction

  function automatic logic [31:0] exp_head();
    return (m_cnt != 0) ? m_q[0] : '0;
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    frm_valid = 1'b0;
    reg_we = 1'b0;
    reg_addr = 2'd0; #1; cmp(tag, "status", reg_rdata, exp_stat());
    reg_addr = 2'd1; #1; cmp(tag, "enable", reg_rdata, {29'b0, m_en});
    reg_addr = 2'd2; #1; cmp(tag, "head", reg_rdata, exp_head());
    reg_addr = 2'd3; #1; cmp(tag, "unmapped", reg_rdata, 32'h0);
    cmp(tag, "irq_nempty", {31'b0, irq_ne}, {31'b0, m_en[0] && (m_cnt != 0)});
    cmp(tag, "irq_full", {31'b0, irq_fu}, {31'b0, m_en[1] && m_full});
    cmp(tag, "irq_ovf", {31'b0, irq_ov}, {31'b0, m_en[2] && m_ovf});
  endtask

  task automatic model_update(input bit push, input logic [31:0] d, input bit we,
                              input logic [1:0] a, input logic [31:0] wd);
    int old_cnt = m_cnt;
    bit pop = m_pend && (m_cnt > 0);
    bit acc = push && ((m_cnt < DEPTH) || pop);
    bit stat_wr = we && (a == 2'd0);
    bit full_set, ovf_set;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end
    if (acc) begin
      m_q[m_cnt] = d;
      m_cnt++;
    end
    full_set = acc && (m_cnt == DEPTH);
    ovf_set = push && !acc;
    m_pend = m_pend ? 1'b0 : (stat_wr && wd[5] && (old_cnt != 0));
    m_full = full_set || (m_full && !(stat_wr && wd[3]));
    m_ovf = ovf_set || (m_ovf && !(stat_wr && wd[4]));
    if (we && (a == 2'd1)) m_en = wd[2:0];
  endtask

  task automatic step(input bit push, input logic [31:0] d, input bit we,
                      input logic [1:0] a, input logic [31:0] wd, input string tag);
    @(negedge clk);
    frm_valid = push; frm_data = d; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model_update(push, d, we, a, wd);
    #1;
    check_state(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, 1'b0, 2'd0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
    m_cnt = 0; m_full = 0; m_ovf = 0; m_pend = 0; m_en = '0;
    void'($urandom(32'h5eed_1234));
    #(CLK_PERIOD * 3);
    check_state("R10");
    @(negedge clk);
    rst_n = 1'b1;

    // R9: enable all lines
    step(0, '0, 1, 2'd1, 32'hFFFF_FFFF, "R9");
    // R2/R3: fill to capacity
    step(1, 32'hA0A0_0001, 0, 2'd0, '0, "R3");
    step(1, 32'hB0B0_0002, 0, 2'd0, '0, "R2");
    step(1, 32'hC0C0_0003, 0, 2'd0, '0, "R4");
    // R5: arrival while full is dropped
    step(1, 32'hDEAD_0004, 0, 2'd0, '0, "R5");
    // R4/R5: writing zeros leaves sticky flags alone
    step(0, '0, 1, 2'd0, 32'h0, "R4");
    // R2: write to head register ignored
    step(0, '0, 1, 2'd2, 32'h1234_5678, "R2");
    // R6: release, pending visible for one cycle
    step(0, '0, 1, 2'd0, 32'h20, "R6");
    idle("R6");
    // R1: reserved bits written as ones stay zero, clears full and ovf
    step(0, '0, 1, 2'd0, 32'hFFFF_FFD8 & ~32'h20, "R1");
    // R11: fill, release, arrival on completion edge
    step(1, 32'hE0E0_0005, 0, 2'd0, '0, "R3");
    step(0, '0, 1, 2'd0, 32'h28, "R6");
    step(1, 32'hF0F0_0006, 0, 2'd0, '0, "R11");
    // R8: overflow set and clear in the same cycle
    step(1, 32'h0BAD_0007, 1, 2'd0, 32'h18, "R8");
    // drain
    for (int k = 0; k < DEPTH; k++) begin
      step(0, '0, 1, 2'd0, 32'h20, "R6");
      idle("R2");
    end
    // R7: release on empty
    step(0, '0, 1, 2'd0, 32'h20, "R7");
    idle("R7");
    // R9: mask lines individually
    step(0, '0, 1, 2'd1, 32'h2, "R9");
    step(1, 32'h1111_0008, 0, 2'd0, '0, "R9");

    for (int n = 0; n < 600; n++) begin
      bit push = ($urandom_range(0, 99) < 55);
      logic [31:0] d = $urandom();
      int sel = $urandom_range(0, 99);
      bit we = sel < 45;
      logic [1:0] a = (sel < 30) ? 2'd0 : (sel < 38) ? 2'd1 : 2'($urandom_range(2, 3));
      logic [31:0] wd = $urandom();
      if (a == 2'd0) wd[5] = ($urandom_range(0, 99) < 70);
      step(push, d, we, a, wd, "RAND");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule